// File: doc/BRIEF.md
# Single-Wire Bit Slot Master

This block is the controlling end of a single open-drain data wire that carries one bit per time slot. A client asks for one slot at a time: a write slot carrying a bit value, or a read slot that recovers a bit from a responding device. Every slot, read or write, starts with this block pulling the wire low. The falling edge is the time reference that the far device uses. How long the wire stays low tells the device which bit is being written. In a read slot, the device may stretch the low level, and the block samples the wire at a fixed delay to recover the bit.

Two timing profiles are available for each request: standard speed and a fast (overdrive) profile. All durations are whole microseconds. They are counted from a tick that a prescaler derives from the clock frequency parameter. The prescaler restarts on every accepted request, so the low pulse always lasts an exact number of ticks. Each slot ends with a recovery interval during which the wire is released. A one-cycle done pulse closes that interval. Grouping bits into bytes and generating bus resets are left to a higher layer.

Top module: `sw_slot_engine`

## Requirements
- R1: After reset the wire is released (`line_oe` = 0), and `busy`, `done`, `req_reject` and `rd_bit` are all 0.
- R2: A request is accepted when `req_valid` = 1 while `busy` = 0. `line_oe` and `busy` go to 1 on the clock edge that accepts it. `line_oe` never rises otherwise.
- R3: In a write slot with `req_bit` = 1, the wire is driven for exactly 6 µs at standard speed (`req_fast` = 0) or 1 µs at fast speed (`req_fast` = 1). One µs is CLK_HZ/1e6 cycles.
- R4: In a write slot with `req_bit` = 0, the wire is driven for exactly 60 µs at standard speed or 7 µs at fast speed.
- R5: In a read slot (`req_read` = 1), the wire is driven for exactly 2 µs at standard speed or 1 µs at fast speed, whatever the value of `req_bit`.
- R6: In a read slot, `rd_bit` takes the level of `line_in` (after a two-stage synchronizer) sampled 13 µs (standard) or 2 µs (fast) after the slot starts. A device holding the wire low gives 0, and a released wire gives 1. Write slots leave `rd_bit` unchanged.
- R7: The slot lasts 65 µs (standard) or 10 µs (fast), and a 2 µs recovery with the wire released follows it. `done` is 1 in the cycle that starts (slot+recovery)·CLK_HZ/1e6 cycles after the accepting edge.
- R8: `done` is high for exactly one cycle. `busy` falls on the same edge on which `done` rises.
- R9: A request made while `busy` = 1 is rejected. `req_reject` is 1 in the next cycle, and the running slot's timing and `rd_bit` are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_HZ |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Slot request strobe |
| req_read | input | 1 | 1 = read slot, 0 = write slot |
| req_bit | input | 1 | Bit value for write slots |
| req_fast | input | 1 | 1 = fast timing profile, 0 = standard |
| busy | output | 1 | A slot or its recovery is in progress |
| req_reject | output | 1 | One-cycle flag: the previous cycle's request came while busy |
| done | output | 1 | One-cycle pulse at the end of recovery |
| rd_bit | output | 1 | Bit recovered by the latest read slot |
| line_oe | output | 1 | 1 = pull the wire low, 0 = release it |
| line_in | input | 1 | Sensed wire level (asynchronous) |

## Verification
The bench runs all four slot kinds (write-0, write-1, read with the device holding the wire low, read with the wire released) under both timing profiles. For each slot it measures the exact number of cycles the wire is driven and the exact cycle of `done`. An off-by-one tick in the prescaler restart, or a swapped profile constant, would show up there as a low pulse or slot length that is wrong by one cycle or by many microseconds. Read results are checked against the device response. A write slot placed between two reads confirms that `rd_bit` holds its value, which catches a design that samples during every slot. Partway through each slot a conflicting request is injected: a design that accepted it would restart or change the wire pattern, and one that failed to flag it would leave `req_reject` low.

// File: rtl/sw_slot_pkg.sv
package sw_slot_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLOT  = 2'd1,
        ST_RECOV = 2'd2
    } slot_st_e;
endpackage

// File: rtl/sw_us_tick.sv
module sw_us_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] presc_d, presc_q;

    always_comb begin
        if (clr || presc_q == LAST) presc_d = '0;
        else                        presc_d = presc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_d;
    end

    assign tick = (presc_q == LAST) && !clr;
endmodule

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = line_in;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], line_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign line_s = sh_q[STAGES-1];
endmodule

// File: rtl/sw_slot_fsm.sv
module sw_slot_fsm
    import sw_slot_pkg::*;
#(
    parameter int W1_STD_US   = 6,
    parameter int W1_OD_US    = 1,
    parameter int W0_STD_US   = 60,
    parameter int W0_OD_US    = 7,
    parameter int RD_STD_US   = 2,
    parameter int RD_OD_US    = 1,
    parameter int SMP_STD_US  = 13,
    parameter int SMP_OD_US   = 2,
    parameter int SLOT_STD_US = 65,
    parameter int SLOT_OD_US  = 10,
    parameter int REC_US      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_s,
    input  logic req_valid,
    input  logic req_read,
    input  logic req_bit,
    input  logic req_fast,
    output logic tick_clr,
    output logic busy,
    output logic req_reject,
    output logic done,
    output logic rd_bit,
    output logic line_oe
);
    localparam int MAXC = (SLOT_STD_US > REC_US) ? SLOT_STD_US : REC_US;
    localparam int CW   = $clog2(MAXC + 1);

    localparam logic [CW-1:0] C_W1_STD   = CW'(W1_STD_US);
    localparam logic [CW-1:0] C_W1_OD    = CW'(W1_OD_US);
    localparam logic [CW-1:0] C_W0_STD   = CW'(W0_STD_US);
    localparam logic [CW-1:0] C_W0_OD    = CW'(W0_OD_US);
    localparam logic [CW-1:0] C_RD_STD   = CW'(RD_STD_US);
    localparam logic [CW-1:0] C_RD_OD    = CW'(RD_OD_US);
    localparam logic [CW-1:0] C_SMP_STD  = CW'(SMP_STD_US);
    localparam logic [CW-1:0] C_SMP_OD   = CW'(SMP_OD_US);
    localparam logic [CW-1:0] C_SLOT_STD = CW'(SLOT_STD_US);
    localparam logic [CW-1:0] C_SLOT_OD  = CW'(SLOT_OD_US);
    localparam logic [CW-1:0] C_REC      = CW'(REC_US);

    typedef struct packed {
        slot_st_e      st;
        logic [CW-1:0] us;
        logic          rd;
        logic          bitv;
        logic          fast;
        logic          oe;
        logic          done;
        logic          rej;
        logic          rdbit;
    } fsm_s;

    fsm_s q, d;
    logic [CW-1:0] low_len, smp_at, slot_len, us_inc;
    logic          clr_d;

    always_comb begin
        if (q.rd)        low_len = q.fast ? C_RD_OD : C_RD_STD;
        else if (q.bitv) low_len = q.fast ? C_W1_OD : C_W1_STD;
        else             low_len = q.fast ? C_W0_OD : C_W0_STD;
        smp_at   = q.fast ? C_SMP_OD  : C_SMP_STD;
        slot_len = q.fast ? C_SLOT_OD : C_SLOT_STD;
        us_inc   = q.us + 1'b1;

        d      = q;
        d.done = 1'b0;
        d.rej  = req_valid && (q.st != ST_IDLE);
        clr_d  = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_SLOT;
                    d.us   = '0;
                    d.rd   = req_read;
                    d.bitv = req_bit;
                    d.fast = req_fast;
                    d.oe   = 1'b1;
                    clr_d  = 1'b1;
                end
            end
            ST_SLOT: begin
                if (tick) begin
                    d.us = us_inc;
                    if (us_inc == low_len)        d.oe    = 1'b0;
                    if (q.rd && us_inc == smp_at) d.rdbit = line_s;
                    if (us_inc == slot_len) begin
                        d.st = ST_RECOV;
                        d.us = '0;
                        d.oe = 1'b0;
                    end
                end
            end
            ST_RECOV: begin
                if (tick) begin
                    d.us = us_inc;
                    if (us_inc == C_REC) begin
                        d.st   = ST_IDLE;
                        d.us   = '0;
                        d.done = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, us: '0, rd: 1'b0, bitv: 1'b0, fast: 1'b0,
                   oe: 1'b0, done: 1'b0, rej: 1'b0, rdbit: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign tick_clr   = clr_d;
    assign busy       = (q.st != ST_IDLE);
    assign req_reject = q.rej;
    assign done       = q.done;
    assign rd_bit     = q.rdbit;
    assign line_oe    = q.oe;
endmodule

// File: rtl/sw_slot_engine.sv
module sw_slot_engine #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SYNC_STAGES = 2,
    parameter int SLOT_STD_US = 65,
    parameter int SLOT_OD_US  = 10,
    parameter int REC_US      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_read,
    input  logic req_bit,
    input  logic req_fast,
    output logic busy,
    output logic req_reject,
    output logic done,
    output logic rd_bit,
    output logic line_oe,
    input  logic line_in
);
    localparam int US_DIV = CLK_HZ / 1_000_000;

    logic tick, tick_clr, line_s;

    sw_us_tick #(.DIV(US_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tick_clr),
        .tick (tick)
    );

    sw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_in),
        .line_s (line_s)
    );

    sw_slot_fsm #(
        .SLOT_STD_US(SLOT_STD_US),
        .SLOT_OD_US (SLOT_OD_US),
        .REC_US     (REC_US)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .line_s    (line_s),
        .req_valid (req_valid),
        .req_read  (req_read),
        .req_bit   (req_bit),
        .req_fast  (req_fast),
        .tick_clr  (tick_clr),
        .busy      (busy),
        .req_reject(req_reject),
        .done      (done),
        .rd_bit    (rd_bit),
        .line_oe   (line_oe)
    );
endmodule

// File: rtl/sw_slot_engine_chk.sv
module sw_slot_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic req_reject,
    input logic done,
    input logic line_oe
);
    // R2
    oe_rise_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> $past(req_valid && !busy));

    // R7
    released_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!line_oe && $past(!line_oe)));

    // R8
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_fall_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9
    reject_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> req_reject);

    // R2
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_oe);
endmodule

bind sw_slot_engine sw_slot_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .req_reject(req_reject),
    .done      (done),
    .line_oe   (line_oe)
);

// File: tb/sw_slot_engine_test.sv
`timescale 1ns/1ps
module sw_slot_engine_test;
    localparam int CLK_HZ = 50_000_000;
    localparam int DIV    = CLK_HZ / 1_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_read = 1'b0, req_bit = 1'b0, req_fast = 1'b0;
    logic busy, req_reject, done, rd_bit, line_oe;
    logic dev_pull = 1'b0;
    logic line_in;

    int checks = 0;
    int errors = 0;
    logic exp_rd = 1'b0;

    always #10 clk = ~clk;

    assign line_in = !(line_oe || dev_pull);

    sw_slot_engine #(.CLK_HZ(CLK_HZ)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_bit(req_bit), .req_fast(req_fast), .busy(busy), .req_reject(req_reject),
        .done(done), .rd_bit(rd_bit), .line_oe(line_oe), .line_in(line_in)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 write-0, 1 write-1, 2 read device-low, 3 read released
    task automatic run_slot(input bit fast, input int kind);
        int low_us, slot_us, hold, total, oe_cnt, oe_first, done_idx, done_cnt;
        bit rd;
        string rq;
        rd      = (kind >= 2);
        slot_us = fast ? 10 : 65;
        if (kind == 0)      begin low_us = fast ? 7 : 60; rq = "R4"; end
        else if (kind == 1) begin low_us = fast ? 1 : 6;  rq = "R3"; end
        else                begin low_us = fast ? 1 : 2;  rq = "R5"; end
        hold  = (fast ? 4 : 20) * DIV;
        total = (slot_us + 2) * DIV;

        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_fast = fast;
        req_bit = (kind == 3) ? 1'b0 : ((kind == 1) ? 1'b1 : 1'b0);
        @(posedge clk);
        oe_cnt = 0; oe_first = 0; done_idx = 0; done_cnt = 0;
        for (int idx = 1; idx <= total + 3; idx++) begin
            @(negedge clk);
            if (idx == 1) begin
                req_valid = 1'b0;
                oe_first = line_oe;
                check("R2 busy after accept", busy, 1);
            end
            dev_pull = (kind == 2) && (idx <= hold);
            if (line_oe) oe_cnt++;
            if (done) begin done_cnt++; if (done_idx == 0) done_idx = idx; end
            if (done) check("R8 busy low with done", busy, 0);
            if (idx == 101) begin
                check("R9 reject flag", req_reject, 1);
                req_valid = 1'b0;
            end
            if (idx == 100) begin
                req_valid = 1'b1; req_read = !rd; req_bit = !req_bit; req_fast = !fast;
            end
        end
        dev_pull = 1'b0;
        check("R2 line driven first cycle", oe_first, 1);
        check(rq, oe_cnt, low_us * DIV);
        check("R7 done cycle", done_idx, total + 1);
        check("R8 done width", done_cnt, 1);
        if (kind == 2) exp_rd = 1'b0;
        if (kind == 3) exp_rd = 1'b1;
        check(rd ? "R6 read value" : "R6 write keeps rd_bit", rd_bit, exp_rd);
    endtask

    initial begin : watchdog
        repeat (150_000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 line released", line_oe, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 reject", req_reject, 0);
        check("R1 rd_bit", rd_bit, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        for (int f = 0; f < 2; f++) begin
            run_slot(f[0], 3);
            run_slot(f[0], 0);
            run_slot(f[0], 2);
            run_slot(f[0], 1);
            run_slot(f[0], 3);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule